// File: doc/BRIEF.md
# Flash Command Interface Controller

A clocked behavioural controller for a byte-wide NOR flash with an 18-bit byte address. Active-low select, read-enable and write-enable strobes are sampled on the clock. They are decoded into four bus modes: read, write, output-disable and standby. Writes feed a multi-cycle command interpreter that unlocks and then runs one of several functions: byte program, sector erase, whole-array erase, identification readout, a boot-sector lock and a return-to-read command.

Program and erase operations are timed by parameterised clock counts and commit into an internal storage array. While an operation is pending, reads return a status byte instead of array data, so software can poll for completion. The boot sector (the top 16 KB) can be locked against program and erase. A lock-status bit is readable in the identification space.

The storage is a scaled model. It holds 2^MEM_AW cells, and each cell backs a contiguous run of 2^(ADDR_W-MEM_AW) byte addresses. The sector layout keeps the same proportions as the full 256 KB address space.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in array-read mode and every cell reads FFH; a read cycle (sel_n=0, rden_n=0, wren_n=1) returns array data with no command.
- R2: d_drive is 1 only while sel_n=0, rden_n=0 and wren_n=1; in standby, output-disable and write modes it is 0.
- R3: One write is accepted per write cycle, on the first clock of sel_n=0, wren_n=0, rden_n=1. Unlock is AAH with addr[14:0]=5555H, then 55H with addr[14:0]=2AAAH. The third write, at 5555H, selects the function: A0H program, 80H erase set-up, 90H identification, F0H return to read. A single F0H write from read or identification mode also returns to read.
- R4: In identification mode, reads decode addr[7:0]: 00H, 01H and 02H return 7FH, 03H returns 8CH, 10H returns the lock bit in bit 0, and any other offset returns 00H.
- R5: After A0H, the next write programs the cell at its address to old AND data once PROG_CYC clocks have passed, so bits can only be cleared.
- R6: The erase set-up (80H) is followed by a second unlock. Then 30H at any address erases that address's sector after SECT_CYC clocks, and 10H at 5555H erases every sector after CHIP_CYC clocks. Sectors are chosen by addr[17:13]: units 0-15 (128 KB), 16-27 (96 KB), 28 (8 KB), 29 (8 KB), and 30-31 (16 KB boot). Erased cells read FFH.
- R7: While busy, a read returns bit 7 = complement of the programmed byte's bit 7 (0 for an erase), bit 6 = a toggle that inverts after each completed read cycle, and bits 5:0 = 0. When the count expires the controller is back in array-read mode.
- R8: Writes issued while an operation is busy have no effect.
- R9: Any write that does not match the expected next cycle of a sequence ends the sequence in array-read mode.
- R10: After the erase set-up and second unlock, 40H at 5555H sets the boot lock immediately, with no busy period; the lock stays set until reset.
- R11: With the lock set, program and sector-erase commands aimed at the boot sector are dropped without a busy period, and a whole-array erase leaves the boot sector unchanged.
- R12: Cell index is addr[ADDR_W-1 -: MEM_AW]; all addresses sharing that index read and write the same cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Active-low device select |
| rden_n | input | 1 | Active-low read (output) enable |
| wren_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Byte address |
| d_in | input | 8 | Write data / command byte |
| d_out | output | 8 | Read data, identification or status byte |
| d_drive | output | 1 | High when d_out should drive the bus |

## Verification
The bound checker watches, on every cycle, that the output drive follows the strobe decode and that status bytes keep their low bits clear. It also checks that the lock never drops once set, that every end of a busy period coincides with a commit, and that no commit touches a locked boot sector. What the checker cannot see is left to the bench's reference model: the exact bytes produced by AND-programming, the extent of each sector erase, the identification codes and the toggle sequence across successive reads. The model also confirms that sequences issued while busy or with a broken unlock leave no trace.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {BUS_STBY, BUS_ODIS, BUS_RD, BUS_WR} bus_mode_e;

    typedef enum logic [3:0] {
        ST_READ, ST_ASEL, ST_U1, ST_U2, ST_PROG, ST_E1, ST_E2, ST_E3, ST_BUSY
    } st_e;

    typedef enum logic [1:0] {OP_PROG, OP_SECT, OP_CHIP} op_e;

    localparam int          NSECT     = 5;
    localparam logic [2:0]  BOOT_SECT = 3'd4;

    localparam logic [14:0] ADR_A = 15'h5555;
    localparam logic [14:0] ADR_B = 15'h2AAA;

    localparam logic [7:0] CMD_UNLK1 = 8'hAA;
    localparam logic [7:0] CMD_UNLK2 = 8'h55;
    localparam logic [7:0] CMD_PROG  = 8'hA0;
    localparam logic [7:0] CMD_ESET  = 8'h80;
    localparam logic [7:0] CMD_ID    = 8'h90;
    localparam logic [7:0] CMD_HOME  = 8'hF0;
    localparam logic [7:0] CMD_SECT  = 8'h30;
    localparam logic [7:0] CMD_CHIP  = 8'h10;
    localparam logic [7:0] CMD_LOCK  = 8'h40;

    // 32 units of 1/32 of the space: 16 + 12 + 1 + 1 + 2
    function automatic logic [2:0] sector_of(input logic [4:0] unit);
        if (unit < 5'd16)       return 3'd0;
        else if (unit < 5'd28)  return 3'd1;
        else if (unit == 5'd28) return 3'd2;
        else if (unit == 5'd29) return 3'd3;
        else                    return 3'd4;
    endfunction

endpackage

// File: rtl/flash_bus_decode.sv
module flash_bus_decode
    import flash_cmd_pkg::*;
(
    input  logic      sel_n,
    input  logic      rden_n,
    input  logic      wren_n,
    output bus_mode_e mode
);

    always_comb begin
        if (sel_n)                   mode = BUS_STBY;
        else if (!wren_n && rden_n)  mode = BUS_WR;
        else if (!rden_n && wren_n)  mode = BUS_RD;
        else                         mode = BUS_ODIS;
    end

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
    import flash_cmd_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MEM_AW-1:0] rd_idx,
    output logic [7:0]        rd_data,
    input  logic              prog_we,
    input  logic [MEM_AW-1:0] prog_idx,
    input  logic [7:0]        prog_data,
    input  logic [NSECT-1:0]  erase_mask
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];

    function automatic logic [4:0] unit_of(input int i);
        logic [MEM_AW-1:0] v;
        v = MEM_AW'(i);
        return v[MEM_AW-1 -: 5];
    endfunction

    assign rd_data = mem_q[rd_idx];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (erase_mask[sector_of(unit_of(i))])
                mem_d[i] = 8'hFF;
            else if (prog_we && (prog_idx == MEM_AW'(i)))
                mem_d[i] = mem_q[i] & prog_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int MEM_AW   = 8,
    parameter int PROG_CYC = 10,
    parameter int SECT_CYC = 40,
    parameter int CHIP_CYC = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_mode_e         mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              busy,
    output logic              lock,
    output logic              asel,
    output logic [7:0]        stat,
    output logic              prog_we,
    output logic [MEM_AW-1:0] prog_idx,
    output logic [7:0]        prog_data,
    output logic [NSECT-1:0]  erase_mask
);

    localparam int MAX_PS = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
    localparam int MAX_C  = (MAX_PS > CHIP_CYC) ? MAX_PS : CHIP_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    typedef struct packed {
        st_e               st;
        op_e               op;
        logic [CNT_W-1:0]  cnt;
        logic [MEM_AW-1:0] tidx;
        logic [7:0]        tdat;
        logic              lock;
        logic              tog;
        logic              wr_prev;
        logic              rd_prev;
    } regs_t;

    regs_t q, d;

    logic wr_go, is_a, is_b, a_boot;

    always_comb begin
        d          = q;
        prog_we    = 1'b0;
        erase_mask = '0;
        wr_go      = (mode == BUS_WR) && !q.wr_prev;
        is_a       = (addr[14:0] == ADR_A);
        is_b       = (addr[14:0] == ADR_B);
        a_boot     = (sector_of(addr[ADDR_W-1 -: 5]) == BOOT_SECT);
        d.wr_prev  = (mode == BUS_WR);
        d.rd_prev  = (mode == BUS_RD);

        case (q.st)
            ST_READ, ST_ASEL: if (wr_go) begin
                if (din == CMD_HOME)                d.st = ST_READ;
                else if (din == CMD_UNLK1 && is_a)  d.st = ST_U1;
                else                                d.st = ST_READ;
            end
            ST_U1: if (wr_go)
                d.st = (din == CMD_UNLK2 && is_b) ? ST_U2 : ST_READ;
            ST_U2: if (wr_go) begin
                d.st = ST_READ;
                if (is_a) begin
                    case (din)
                        CMD_PROG: d.st = ST_PROG;
                        CMD_ESET: d.st = ST_E1;
                        CMD_ID:   d.st = ST_ASEL;
                        default:  d.st = ST_READ;
                    endcase
                end
            end
            ST_PROG: if (wr_go) begin
                if (a_boot && q.lock) begin
                    d.st = ST_READ;
                end else begin
                    d.st   = ST_BUSY;
                    d.op   = OP_PROG;
                    d.tidx = addr[ADDR_W-1 -: MEM_AW];
                    d.tdat = din;
                    d.cnt  = CNT_W'(PROG_CYC);
                end
            end
            ST_E1: if (wr_go)
                d.st = (din == CMD_UNLK1 && is_a) ? ST_E2 : ST_READ;
            ST_E2: if (wr_go)
                d.st = (din == CMD_UNLK2 && is_b) ? ST_E3 : ST_READ;
            ST_E3: if (wr_go) begin
                d.st = ST_READ;
                if (din == CMD_SECT) begin
                    if (!(a_boot && q.lock)) begin
                        d.st   = ST_BUSY;
                        d.op   = OP_SECT;
                        d.tidx = addr[ADDR_W-1 -: MEM_AW];
                        d.tdat = 8'hFF;
                        d.cnt  = CNT_W'(SECT_CYC);
                    end
                end else if (din == CMD_CHIP && is_a) begin
                    d.st   = ST_BUSY;
                    d.op   = OP_CHIP;
                    d.tdat = 8'hFF;
                    d.cnt  = CNT_W'(CHIP_CYC);
                end else if (din == CMD_LOCK && is_a) begin
                    d.lock = 1'b1;
                end
            end
            ST_BUSY: begin
                if (q.rd_prev && (mode != BUS_RD)) d.tog = !q.tog;
                if (q.cnt == CNT_W'(1)) begin
                    d.st = ST_READ;
                    case (q.op)
                        OP_PROG: prog_we = 1'b1;
                        OP_SECT: erase_mask[sector_of(q.tidx[MEM_AW-1 -: 5])] = 1'b1;
                        default: begin
                            erase_mask = '1;
                            if (q.lock) erase_mask[BOOT_SECT] = 1'b0;
                        end
                    endcase
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            default: d.st = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st      <= ST_READ;
            q.op      <= OP_PROG;
            q.cnt     <= '0;
            q.tidx    <= '0;
            q.tdat    <= 8'hFF;
            q.lock    <= 1'b0;
            q.tog     <= 1'b0;
            q.wr_prev <= 1'b0;
            q.rd_prev <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st == ST_BUSY);
    assign asel      = (q.st == ST_ASEL);
    assign lock      = q.lock;
    assign stat      = {~q.tdat[7], q.tog, 6'b0};
    assign prog_idx  = q.tidx;
    assign prog_data = q.tdat;

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int MEM_AW   = 8,
    parameter int PROG_CYC = 10,
    parameter int SECT_CYC = 40,
    parameter int CHIP_CYC = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              rden_n,
    input  logic              wren_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        d_in,
    output logic [7:0]        d_out,
    output logic              d_drive
);

    bus_mode_e         mode;
    logic              busy, lock, asel, prog_we;
    logic [7:0]        stat, prog_data, rd_data, id_byte;
    logic [MEM_AW-1:0] prog_idx;
    logic [NSECT-1:0]  erase_mask;

    flash_bus_decode u_dec (
        .sel_n  (sel_n),
        .rden_n (rden_n),
        .wren_n (wren_n),
        .mode   (mode)
    );

    flash_cmd_fsm #(
        .ADDR_W   (ADDR_W),
        .MEM_AW   (MEM_AW),
        .PROG_CYC (PROG_CYC),
        .SECT_CYC (SECT_CYC),
        .CHIP_CYC (CHIP_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .addr       (addr),
        .din        (d_in),
        .busy       (busy),
        .lock       (lock),
        .asel       (asel),
        .stat       (stat),
        .prog_we    (prog_we),
        .prog_idx   (prog_idx),
        .prog_data  (prog_data),
        .erase_mask (erase_mask)
    );

    flash_cell_array #(.MEM_AW(MEM_AW)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (addr[ADDR_W-1 -: MEM_AW]),
        .rd_data    (rd_data),
        .prog_we    (prog_we),
        .prog_idx   (prog_idx),
        .prog_data  (prog_data),
        .erase_mask (erase_mask)
    );

    always_comb begin
        case (addr[7:0])
            8'h00, 8'h01, 8'h02: id_byte = 8'h7F;
            8'h03:               id_byte = 8'h8C;
            8'h10:               id_byte = {7'b0, lock};
            default:             id_byte = 8'h00;
        endcase
        if (busy)      d_out = stat;
        else if (asel) d_out = id_byte;
        else           d_out = rd_data;
    end

    assign d_drive = (mode == BUS_RD);

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
    parameter int MEM_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              rden_n,
    input logic              wren_n,
    input logic              d_drive,
    input logic [7:0]        d_out,
    input logic              busy,
    input logic              lock,
    input logic              prog_we,
    input logic [MEM_AW-1:0] prog_idx,
    input logic [4:0]        erase_mask
);

    // R2
    drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_drive |-> (!sel_n && !rden_n && wren_n));

    // R7
    status_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && d_drive) |-> (d_out[5:0] == 6'b0));

    // R10
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    // R11
    boot_prog_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_we && lock) |-> (prog_idx[MEM_AW-1 -: 4] != 4'hF));

    // R11
    boot_erase_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> !erase_mask[4]);

    // R5 R6
    busy_end_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(prog_we || (|erase_mask)));

endmodule

bind flash_cmd_ctrl flash_cmd_chk #(.MEM_AW(MEM_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n      (sel_n),
    .rden_n     (rden_n),
    .wren_n     (wren_n),
    .d_drive    (d_drive),
    .d_out      (d_out),
    .busy       (busy),
    .lock       (lock),
    .prog_we    (prog_we),
    .prog_idx   (prog_idx),
    .erase_mask (erase_mask)
);

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;

    localparam int CLK_NS = 10;
    localparam int Q      = 2;
    localparam int PROG   = 10;
    localparam int SECT   = 40;
    localparam int CHIP   = 80;

    localparam int S_RD = 0, S_AS = 1, S_U1 = 2, S_U2 = 3, S_PG = 4,
                   S_E1 = 5, S_E2 = 6, S_E3 = 7, S_BZ = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1, rden_n = 1'b1, wren_n = 1'b1;
    logic [17:0] addr = '0;
    logic [7:0]  d_in = '0;
    logic [7:0]  d_out;
    logic        d_drive;

    always #(CLK_NS/2) clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(18), .MEM_AW(8), .PROG_CYC(PROG),
                     .SECT_CYC(SECT), .CHIP_CYC(CHIP)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rden_n(rden_n),
        .wren_n(wren_n), .addr(addr), .d_in(d_in), .d_out(d_out),
        .d_drive(d_drive)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int         m_st, m_cnt, m_op, m_tidx;
    logic [7:0] m_tdat;
    bit         m_lock, m_tog, m_wrp, m_rdp;
    logic [7:0] mem [256];
    bit         b_wr, b_rd, b_go, b_a, b_b, b_boot;

    function automatic int m_sect(input int unit);
        if (unit < 16) return 0;
        if (unit < 28) return 1;
        if (unit == 28) return 2;
        if (unit == 29) return 3;
        return 4;
    endfunction

    function automatic logic [7:0] m_id(input logic [17:0] a);
        if (a[7:0] <= 8'h02) return 8'h7F;
        if (a[7:0] == 8'h03) return 8'h8C;
        if (a[7:0] == 8'h10) return {7'b0, m_lock};
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = S_RD; m_cnt = 0; m_op = 0; m_tidx = 0; m_tdat = 8'hFF;
            m_lock = 0; m_tog = 0; m_wrp = 0; m_rdp = 0;
            for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        end else begin
            b_wr   = !sel_n && !wren_n && rden_n;
            b_rd   = !sel_n && !rden_n && wren_n;
            b_go   = b_wr && !m_wrp;
            b_a    = (addr[14:0] == 15'h5555);
            b_b    = (addr[14:0] == 15'h2AAA);
            b_boot = (addr[17:14] == 4'hF);
            if (m_st == S_BZ) begin
                if (m_rdp && !b_rd) m_tog = !m_tog;
                if (m_cnt == 1) begin
                    m_st = S_RD;
                    if (m_op == 0) mem[m_tidx] = mem[m_tidx] & m_tdat;
                    else for (int i = 0; i < 256; i++)
                        if ((m_op == 2 && !(m_lock && i >= 240)) ||
                            (m_op == 1 && m_sect(i >> 3) == m_sect(m_tidx >> 3)))
                            mem[i] = 8'hFF;
                end else m_cnt--;
            end else if (b_go) begin
                case (m_st)
                    S_RD, S_AS: m_st = (d_in == 8'hAA && b_a) ? S_U1 : S_RD;
                    S_U1: m_st = (d_in == 8'h55 && b_b) ? S_U2 : S_RD;
                    S_U2: begin
                        m_st = S_RD;
                        if (b_a && d_in == 8'hA0) m_st = S_PG;
                        if (b_a && d_in == 8'h80) m_st = S_E1;
                        if (b_a && d_in == 8'h90) m_st = S_AS;
                    end
                    S_PG: begin
                        m_st = S_RD;
                        if (!(b_boot && m_lock)) begin
                            m_st = S_BZ; m_op = 0; m_tidx = int'(addr[17:10]);
                            m_tdat = d_in; m_cnt = PROG;
                        end
                    end
                    S_E1: m_st = (d_in == 8'hAA && b_a) ? S_E2 : S_RD;
                    S_E2: m_st = (d_in == 8'h55 && b_b) ? S_E3 : S_RD;
                    S_E3: begin
                        m_st = S_RD;
                        if (d_in == 8'h30) begin
                            if (!(b_boot && m_lock)) begin
                                m_st = S_BZ; m_op = 1; m_tidx = int'(addr[17:10]);
                                m_tdat = 8'hFF; m_cnt = SECT;
                            end
                        end else if (b_a && d_in == 8'h10) begin
                            m_st = S_BZ; m_op = 2; m_tdat = 8'hFF; m_cnt = CHIP;
                        end else if (b_a && d_in == 8'h40) m_lock = 1;
                    end
                    default: m_st = S_RD;
                endcase
            end
            m_wrp = b_wr;
            m_rdp = b_rd;
        end
    end

    // per-clock comparison against the model
    logic [7:0] e_d;
    bit         e_oe;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            e_oe = !sel_n && !rden_n && wren_n;
            chk(d_drive == e_oe, "R2 drive", {7'b0, d_drive}, {7'b0, e_oe});
            if (e_oe) begin
                if (m_st == S_BZ) begin
                    e_d = {~m_tdat[7], m_tog, 6'b0};
                    chk(d_out == e_d, "R7 model status", d_out, e_d);
                end else if (m_st == S_AS) begin
                    e_d = m_id(addr);
                    chk(d_out == e_d, "R4 model id", d_out, e_d);
                end else begin
                    e_d = mem[addr[17:10]];
                    chk(d_out == e_d, "R1 model array", d_out, e_d);
                end
            end
        end
    end

    // ---------------- bus tasks ----------------
    task automatic go_idle();
        sel_n = 1'b1; rden_n = 1'b1; wren_n = 1'b1;
    endtask

    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        @(posedge clk); #Q;
        sel_n = 1'b0; rden_n = 1'b1; wren_n = 1'b0; addr = a; d_in = d;
        @(posedge clk); @(posedge clk); #Q;
        go_idle();
    endtask

    task automatic rd_chk(input logic [17:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #Q;
        sel_n = 1'b0; rden_n = 1'b0; wren_n = 1'b1; addr = a;
        @(negedge clk);
        chk(d_drive === 1'b1 && d_out === exp, tag, d_out, exp);
        @(posedge clk); #Q;
        go_idle();
    endtask

    task automatic bus_chk(input logic s, input logic r, input logic w, input string tag);
        @(posedge clk); #Q;
        sel_n = s; rden_n = r; wren_n = w; d_in = 8'h00; addr = 18'h00000;
        @(negedge clk);
        chk(d_drive === 1'b0, tag, {7'b0, d_drive}, 8'h00);
        @(posedge clk); #Q;
        go_idle();
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic unl();
        wr(18'h05555, 8'hAA);
        wr(18'h02AAA, 8'h55);
    endtask

    task automatic prog(input logic [17:0] a, input logic [7:0] d);
        unl();
        wr(18'h05555, 8'hA0);
        wr(a, d);
    endtask

    task automatic erase_pre();
        unl();
        wr(18'h05555, 8'h80);
        unl();
    endtask

    // ---------------- scenarios ----------------
    initial begin
        repeat (3) @(posedge clk);
        #Q rst_n = 1'b1;

        // R1 reset state
        rd_chk(18'h00000, 8'hFF, "R1 reset read low");
        rd_chk(18'h3FFFF, 8'hFF, "R1 reset read high");

        // R2 non-read modes
        bus_chk(1'b1, 1'b0, 1'b1, "R2 standby");
        bus_chk(1'b0, 1'b1, 1'b1, "R2 output disable");
        bus_chk(1'b0, 1'b1, 1'b0, "R2 write mode");

        // R5 R7 program with status polling (bit7 of 3C is 0 -> status bit7 = 1)
        prog(18'h00400, 8'h3C);
        rd_chk(18'h00400, 8'h80, "R7 poll first");
        rd_chk(18'h00400, 8'hC0, "R7 poll toggled");
        idle(12);
        rd_chk(18'h00400, 8'h3C, "R5 program");

        // R5 AND programming; R8 commands during busy ignored
        prog(18'h00400, 8'hF0);
        unl();
        wr(18'h05555, 8'h90);
        idle(4);
        rd_chk(18'h00400, 8'h30, "R8 busy writes ignored");
        rd_chk(18'h00000, 8'hFF, "R8 not in id mode");
        rd_chk(18'h00400, 8'h30, "R5 and-program");
        rd_chk(18'h007FF, 8'h30, "R12 alias");

        // R4 identification, R3 return to read
        unl();
        wr(18'h05555, 8'h90);
        rd_chk(18'h00000, 8'h7F, "R4 id 0");
        rd_chk(18'h00001, 8'h7F, "R4 id 1");
        rd_chk(18'h00002, 8'h7F, "R4 id 2");
        rd_chk(18'h00003, 8'h8C, "R4 id 3");
        rd_chk(18'h00010, 8'h00, "R4 lock open");
        rd_chk(18'h00055, 8'h00, "R4 other");
        wr(18'h00000, 8'hF0);
        rd_chk(18'h00003, 8'hFF, "R3 home cmd");

        // R9 broken sequence
        wr(18'h05555, 8'hAA);
        wr(18'h01234, 8'h55);
        wr(18'h05555, 8'h90);
        rd_chk(18'h00000, 8'hFF, "R9 abort");

        // R6 sector erase
        prog(18'h20000, 8'h00); idle(12);
        prog(18'h10000, 8'h55); idle(12);
        prog(18'h38000, 8'h12); idle(12);
        prog(18'h3E000, 8'hA5); idle(12);
        erase_pre();
        wr(18'h2A000, 8'h30);
        rd_chk(18'h2A000, 8'h00, "R7 erase poll");
        rd_chk(18'h2A000, 8'h40, "R7 erase toggle");
        idle(45);
        rd_chk(18'h20000, 8'hFF, "R6 sector erased");
        rd_chk(18'h10000, 8'h55, "R6 other sector kept");
        rd_chk(18'h38000, 8'h12, "R6 small sector kept");

        // R10 lock
        erase_pre();
        wr(18'h05555, 8'h40);
        rd_chk(18'h3E000, 8'hA5, "R10 no busy on lock");
        unl();
        wr(18'h05555, 8'h90);
        rd_chk(18'h00010, 8'h01, "R10 lock status");
        wr(18'h00000, 8'hF0);

        // R11 locked boot sector
        prog(18'h3C000, 8'h00);
        rd_chk(18'h3C000, 8'hFF, "R11 locked program dropped");
        erase_pre();
        wr(18'h3E000, 8'h30);
        rd_chk(18'h3E000, 8'hA5, "R11 locked erase dropped");
        erase_pre();
        wr(18'h05555, 8'h10);
        idle(90);
        rd_chk(18'h10000, 8'hFF, "R6 chip erase");
        rd_chk(18'h38000, 8'hFF, "R6 chip erase small");
        rd_chk(18'h00400, 8'hFF, "R6 chip erase first");
        rd_chk(18'h3E000, 8'hA5, "R11 boot kept on chip erase");

        idle(3);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule